// File: doc/BRIEF.md
# Inbound Virtual Wire Group

This block keeps the state of four inbound virtual wires that a host drives across the serial side-band link. A protocol front end, outside this block, decodes host packets and offers each one as an index, a four-bit valid mask and four data bits. The group accepts the update only when the index equals the index that software has programmed for it. Each wire whose valid bit is set takes its data bit, and the other wires keep their state.

Software sees three 32-bit words. Word 0 holds the host index, the reset source select and a four-bit reset state. Word 1 holds one four-bit interrupt mode per wire. Word 2 shows the wire levels and the edge-pending flags; software writes a 1 to a pending flag to clear it. Four reset inputs are sampled on every clock. A rising edge on the input that software has selected loads the reset state into the wires. Each wire drives its own interrupt output. In a level mode the output follows the wire. In an edge mode it shows a pending flag that the chosen transition sets.

Top module: `hvw_group`

## Requirements
- R1: After the block reset, word 0 reads 0x00000000, word 1 reads 0x04040404 (all wires disabled), word 2 reads 0x00000000, and all interrupt outputs are 0.
- R2: Word 0 holds the host index at bits [7:0], the reset source at bits [9:8] and the reset state at bits [15:12]. All other bits of word 0 read as 0, whatever value was written to them.
- R3: A host update whose index equals the programmed index changes only the wires whose valid bit is set. Word 2 shows the new levels one clock later, with wire i at bit 8*i.
- R4: A host update is ignored when its index differs from the programmed index, and also when the programmed index is below 2.
- R5: The reset source value n (0 to 3) selects reset input n. A rising edge on that input, seen between two clock samples, loads bit i of the reset state into wire i. Rising edges on the other reset inputs have no effect.
- R6: When a reset load and a matching host update arrive in the same cycle, the reset load wins. A reset load never sets an edge-pending flag.
- R7: Word 1 holds the mode of wire i at bits [8*i+3:8*i]. In mode 0 the interrupt output is the inverse of the wire level. In mode 1 it equals the wire level. Both follow the wire without a register stage.
- R8: Mode 13 sets the wire's pending flag on a 0-to-1 change, mode 14 on a 1-to-0 change, and mode 15 on either change, one clock after the change. In these modes the interrupt output equals the flag. The flag reads at word 2 bit 8*i+1 and stays set until a write to word 2 with that bit set to 1 clears it.
- R9: Mode 4 and every mode value not named in R7 or R8 keep the interrupt output at 0 and never set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select (0, 1, 2; 3 reads as zero) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| upd_valid | input | 1 | Host update strobe from the front end |
| upd_index | input | 8 | Index carried by the host update |
| upd_mask | input | 4 | Per-wire valid bits of the update |
| upd_data | input | 4 | Per-wire data bits of the update |
| rst_pins | input | 4 | Reset inputs: eSPI, system, super-I/O, platform |
| irq | output | 4 | Per-wire interrupt outputs |

## Verification
The assertions assume that the front end presents an update strobe for one clock only and keeps its index, mask and data stable while the strobe is high. They also assume that the reset inputs are synchronous to the block clock, so that a rising edge shows up as one sampled low-to-high step. The bench drives every input on the falling clock edge, raises each strobe for exactly one cycle, and holds each reset input high for at least two clocks before it lowers it. Every edge the design sees is therefore one clean step.

// File: rtl/hvw_pkg.sv
package hvw_pkg;

  localparam int unsigned SEL_W  = 4;
  localparam int unsigned WORD_W = 32;

  localparam logic [SEL_W-1:0] SEL_LOW  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_HIGH = 4'd1;
  localparam logic [SEL_W-1:0] SEL_OFF  = 4'd4;
  localparam logic [SEL_W-1:0] SEL_RISE = 4'd13;
  localparam logic [SEL_W-1:0] SEL_FALL = 4'd14;
  localparam logic [SEL_W-1:0] SEL_ANY  = 4'd15;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_LOW,
    MODE_HIGH,
    MODE_RISE,
    MODE_FALL,
    MODE_ANY
  } irq_mode_e;

  // Map the software code to a mode; unknown codes are treated as off.
  function automatic irq_mode_e sel_to_mode(input logic [SEL_W-1:0] s);
    case (s)
      SEL_LOW:  return MODE_LOW;
      SEL_HIGH: return MODE_HIGH;
      SEL_RISE: return MODE_RISE;
      SEL_FALL: return MODE_FALL;
      SEL_ANY:  return MODE_ANY;
      default:  return MODE_OFF;
    endcase
  endfunction

  function automatic logic mode_is_edge(input irq_mode_e m);
    return (m == MODE_RISE) || (m == MODE_FALL) || (m == MODE_ANY);
  endfunction

  // Transition test between the previous and current sample of one wire.
  function automatic logic edge_match(input irq_mode_e m, input logic cur,
                                      input logic prev);
    case (m)
      MODE_RISE: return cur & ~prev;
      MODE_FALL: return ~cur & prev;
      MODE_ANY:  return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic level_out(input irq_mode_e m, input logic cur);
    case (m)
      MODE_LOW:  return ~cur;
      MODE_HIGH: return cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hvw_cfg_regs.sv
module hvw_cfg_regs
  import hvw_pkg::*;
#(
  parameter int unsigned NUM_WIRES = 4,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned LANE      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [IDX_W-1:0]        host_idx,
  output logic [SRC_W-1:0]        rst_sel,
  output logic [NUM_WIRES-1:0]    rst_state,
  output logic [NUM_WIRES*SEL_W-1:0] wire_sel,
  output logic [WORD_W-1:0]       word0_rd,
  output logic [WORD_W-1:0]       word1_rd
);

  localparam int unsigned SRC_LSB = 8;
  localparam int unsigned RST_LSB = 12;

  logic wr0, wr1;
  assign wr0 = wr_en && (wr_addr == 2'd0);
  assign wr1 = wr_en && (wr_addr == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_idx  <= '0;
      rst_sel   <= '0;
      rst_state <= '0;
    end else if (wr0) begin
      host_idx  <= wr_data[IDX_W-1:0];
      rst_sel   <= wr_data[SRC_LSB +: SRC_W];
      rst_state <= wr_data[RST_LSB +: NUM_WIRES];
    end
  end

  for (genvar i = 0; i < NUM_WIRES; i++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wire_sel[i*SEL_W +: SEL_W] <= SEL_OFF;
      end else if (wr1) begin
        wire_sel[i*SEL_W +: SEL_W] <= wr_data[i*LANE +: SEL_W];
      end
    end
  end

  always_comb begin
    word0_rd = '0;
    word0_rd[IDX_W-1:0]            = host_idx;
    word0_rd[SRC_LSB +: SRC_W]     = rst_sel;
    word0_rd[RST_LSB +: NUM_WIRES] = rst_state;
    word1_rd = '0;
    for (int i = 0; i < NUM_WIRES; i++) begin
      word1_rd[i*LANE +: SEL_W] = wire_sel[i*SEL_W +: SEL_W];
    end
  end

  // R2
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr0 |=> $stable(host_idx) && $stable(rst_sel) && $stable(rst_state));

endmodule

// File: rtl/hvw_wire_state.sv
module hvw_wire_state #(
  parameter int unsigned NUM_WIRES = 4,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned NUM_RST   = 4,
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned MIN_IDX   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic [IDX_W-1:0]     upd_index,
  input  logic [NUM_WIRES-1:0] upd_mask,
  input  logic [NUM_WIRES-1:0] upd_data,
  input  logic [IDX_W-1:0]     host_idx,
  input  logic [SRC_W-1:0]     rst_sel,
  input  logic [NUM_WIRES-1:0] rst_state,
  input  logic [NUM_RST-1:0]   rst_pins,
  output logic [NUM_WIRES-1:0] wire_q,
  output logic [NUM_WIRES-1:0] wire_prev,
  output logic                 upd_hit,
  output logic                 rst_load
);

  localparam logic [IDX_W-1:0] MIN_IDX_V = IDX_W'(MIN_IDX);

  logic [NUM_RST-1:0]   pins_q;
  logic [NUM_RST-1:0]   pins_rise;
  logic                 idx_ok;
  logic [NUM_WIRES-1:0] merged;

  assign pins_rise = rst_pins & ~pins_q;
  assign rst_load  = pins_rise[rst_sel];
  assign idx_ok    = host_idx >= MIN_IDX_V;
  assign upd_hit   = upd_valid && idx_ok && (upd_index == host_idx);
  assign merged    = (wire_q & ~upd_mask) | (upd_data & upd_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q    <= '0;
      wire_q    <= '0;
      wire_prev <= '0;
    end else begin
      pins_q <= rst_pins;
      if (rst_load) begin
        wire_q    <= rst_state;
        wire_prev <= rst_state;
      end else begin
        wire_prev <= wire_q;
        if (upd_hit) wire_q <= merged;
      end
    end
  end

  // R4
  upd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_hit && !rst_load) |=> $stable(wire_q));

  // R4
  low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (host_idx < MIN_IDX_V) && !rst_load) |=> $stable(wire_q));

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && !rst_load) |=> (((wire_q ^ $past(wire_q)) & ~$past(upd_mask)) == '0));

  // R5
  rst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_load |=> (wire_q == $past(rst_state)));

endmodule

// File: rtl/hvw_irq_unit.sv
module hvw_irq_unit
  import hvw_pkg::*;
#(
  parameter int unsigned NUM_WIRES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WIRES-1:0]       wire_q,
  input  logic [NUM_WIRES-1:0]       wire_prev,
  input  logic [NUM_WIRES*SEL_W-1:0] wire_sel,
  input  logic [NUM_WIRES-1:0]       clr_mask,
  output logic [NUM_WIRES-1:0]       edge_evt,
  output logic [NUM_WIRES-1:0]       pend_q,
  output logic [NUM_WIRES-1:0]       irq
);

  for (genvar i = 0; i < NUM_WIRES; i++) begin : g_wire
    irq_mode_e mode;
    assign mode        = sel_to_mode(wire_sel[i*SEL_W +: SEL_W]);
    assign edge_evt[i] = edge_match(mode, wire_q[i], wire_prev[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pend_q[i] <= 1'b0;
      else if (edge_evt[i])   pend_q[i] <= 1'b1;
      else if (clr_mask[i])   pend_q[i] <= 1'b0;
    end

    assign irq[i] = mode_is_edge(mode) ? pend_q[i] : level_out(mode, wire_q[i]);

    // R8
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_evt[i] |=> !$rose(pend_q[i]));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_mask[i]) |=> pend_q[i]);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_OFF) |-> (!irq[i] && !edge_evt[i]));
  end

endmodule

// File: rtl/hvw_group.sv
module hvw_group
  import hvw_pkg::*;
#(
  parameter int unsigned NUM_WIRES = 4,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned NUM_RST   = 4,
  parameter int unsigned MIN_IDX   = 2,
  parameter int unsigned LANE      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wen,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 upd_valid,
  input  logic [IDX_W-1:0]     upd_index,
  input  logic [NUM_WIRES-1:0] upd_mask,
  input  logic [NUM_WIRES-1:0] upd_data,
  input  logic [NUM_RST-1:0]   rst_pins,
  output logic [NUM_WIRES-1:0] irq
);

  localparam int unsigned SRC_W    = (NUM_RST > 1) ? $clog2(NUM_RST) : 1;
  localparam int unsigned PEND_OFS = 1;

  logic [IDX_W-1:0]           host_idx;
  logic [SRC_W-1:0]           rst_sel;
  logic [NUM_WIRES-1:0]       rst_state;
  logic [NUM_WIRES*SEL_W-1:0] wire_sel;
  logic [WORD_W-1:0]          word0_rd, word1_rd, word2_rd;
  logic [NUM_WIRES-1:0]       wire_q, wire_prev, edge_evt, pend_q, clr_mask;
  logic                       upd_hit, rst_load, clr_wr;

  hvw_cfg_regs #(
    .NUM_WIRES(NUM_WIRES), .IDX_W(IDX_W), .SRC_W(SRC_W), .LANE(LANE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wen), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .host_idx(host_idx), .rst_sel(rst_sel),
    .rst_state(rst_state), .wire_sel(wire_sel),
    .word0_rd(word0_rd), .word1_rd(word1_rd)
  );

  hvw_wire_state #(
    .NUM_WIRES(NUM_WIRES), .IDX_W(IDX_W), .NUM_RST(NUM_RST),
    .SRC_W(SRC_W), .MIN_IDX(MIN_IDX)
  ) u_wires (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_index(upd_index),
    .upd_mask(upd_mask), .upd_data(upd_data), .host_idx(host_idx),
    .rst_sel(rst_sel), .rst_state(rst_state), .rst_pins(rst_pins),
    .wire_q(wire_q), .wire_prev(wire_prev), .upd_hit(upd_hit),
    .rst_load(rst_load)
  );

  assign clr_wr = reg_wen && (reg_addr == 2'd2);
  for (genvar i = 0; i < NUM_WIRES; i++) begin : g_clr
    assign clr_mask[i] = clr_wr && reg_wdata[i*LANE + PEND_OFS];
  end

  hvw_irq_unit #(
    .NUM_WIRES(NUM_WIRES)
  ) u_irq (
    .clk(clk), .rst_n(rst_n), .wire_q(wire_q), .wire_prev(wire_prev),
    .wire_sel(wire_sel), .clr_mask(clr_mask), .edge_evt(edge_evt),
    .pend_q(pend_q), .irq(irq)
  );

  always_comb begin
    word2_rd = '0;
    for (int i = 0; i < NUM_WIRES; i++) begin
      word2_rd[i*LANE]            = wire_q[i];
      word2_rd[i*LANE + PEND_OFS] = pend_q[i];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = word0_rd;
      2'd1:    reg_rdata = word1_rd;
      2'd2:    reg_rdata = word2_rd;
      default: reg_rdata = '0;
    endcase
  end

  // R6
  load_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_load |=> !edge_evt);

endmodule

// File: tb/hvw_group_test.sv
module hvw_group_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        upd_valid = 1'b0;
  logic [7:0]  upd_index = '0;
  logic [3:0]  upd_mask = '0;
  logic [3:0]  upd_data = '0;
  logic [3:0]  rst_pins = '0;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;

  hvw_group uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_valid(upd_valid),
    .upd_index(upd_index), .upd_mask(upd_mask), .upd_data(upd_data),
    .rst_pins(rst_pins), .irq(irq)
  );

  always #2 clk = ~clk;

  // Host update table: index, mask, data, expected levels after it.
  localparam logic [19:0] UPD_TAB [6] = '{
    {8'h25, 4'hF, 4'h5, 4'h5},
    {8'h24, 4'hF, 4'hA, 4'h5},
    {8'h25, 4'h2, 4'hF, 4'h7},
    {8'h25, 4'h0, 4'h0, 4'h7},
    {8'h25, 4'h9, 4'h0, 4'h6},
    {8'h25, 4'h8, 4'h8, 4'hE}
  };

  function automatic logic [31:0] pack2(input logic [3:0] lv, input logic [3:0] pd);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) begin
      w[8*i]   = lv[i];
      w[8*i+1] = pd[i];
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic upd(input logic [7:0] ix, input logic [3:0] m, input logic [3:0] dt);
    @(negedge clk);
    upd_valid = 1'b1; upd_index = ix; upd_mask = m; upd_data = dt;
    @(negedge clk);
    upd_valid = 1'b0;
    @(negedge clk);  // let the pending stage settle
  endtask

  task automatic pulse_pin(input int n);
    @(negedge clk);
    rst_pins[n] = 1'b1;
    repeat (2) @(negedge clk);
    rst_pins[n] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, r); chk("R1 word0", r, 32'h0);
    rd(2'd1, r); chk("R1 word1", r, 32'h04040404);
    rd(2'd2, r); chk("R1 word2", r, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);

    // Programmed index 0 is below the minimum, so even a matching index is ignored.
    upd(8'h00, 4'hF, 4'hF);
    rd(2'd2, r); chk("R4 index below 2", r, 32'h0);

    wr(2'd0, 32'hFFFFA625);
    rd(2'd0, r); chk("R2 word0 fields", r, 32'h0000A225);

    for (int k = 0; k < 6; k++) begin
      upd(UPD_TAB[k][19:12], UPD_TAB[k][11:8], UPD_TAB[k][7:4]);
      rd(2'd2, r);
      chk((UPD_TAB[k][19:12] == 8'h25) ? "R3 update" : "R4 mismatch",
          r, pack2(UPD_TAB[k][3:0], 4'h0));
    end

    pulse_pin(0);
    rd(2'd2, r); chk("R5 unselected pin", r, pack2(4'hE, 4'h0));
    pulse_pin(2);
    rd(2'd2, r); chk("R5 selected pin load", r, pack2(4'hA, 4'h0));

    // R6: reset load and matching update in the same cycle.
    upd(8'h25, 4'hF, 4'h0);
    rd(2'd2, r); chk("R3 clear all", r, pack2(4'h0, 4'h0));
    @(negedge clk);
    upd_valid = 1'b1; upd_index = 8'h25; upd_mask = 4'hF; upd_data = 4'h0;
    rst_pins[2] = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    @(negedge clk);
    rst_pins[2] = 1'b0;
    rd(2'd2, r); chk("R6 load wins", r, pack2(4'hA, 4'h0));

    wr(2'd1, 32'h0F0F0F0F);
    wr(2'd0, 32'h00005225);
    pulse_pin(2);
    rd(2'd2, r); chk("R6 load no pending", r, pack2(4'h5, 4'h0));
    chk("R6 irq quiet", {28'h0, irq}, 32'h0);

    // R7 / R9: wire0 low level, wire1 high level, wire2 off, wire3 code 7.
    wr(2'd1, 32'h07040100);
    rd(2'd1, r); chk("R7 word1 readback", r, 32'h07040100);
    upd(8'h25, 4'hF, 4'h6);
    chk("R7 level irq", {28'h0, irq}, 32'h3);
    upd(8'h25, 4'hF, 4'h9);
    chk("R7 level irq follows", {28'h0, irq}, 32'h0);
    rd(2'd2, r); chk("R9 unlisted code no pending", r, pack2(4'h9, 4'h0));

    // R8: wire0 rise, wire1 fall, wire2 either, wire3 off. Levels now 9.
    wr(2'd1, 32'h040F0E0D);
    upd(8'h25, 4'hF, 4'h6);
    chk("R8 either edge", {28'h0, irq}, 32'h4);
    rd(2'd2, r); chk("R8 pending bits", r, pack2(4'h6, 4'h4));
    upd(8'h25, 4'hF, 4'h9);
    chk("R8 rise and fall", {28'h0, irq}, 32'h7);
    repeat (5) @(negedge clk);
    chk("R8 pending held", {28'h0, irq}, 32'h7);
    wr(2'd2, 32'h00020000);
    chk("R8 clear one", {28'h0, irq}, 32'h3);
    wr(2'd2, 32'h03030303);
    rd(2'd2, r); chk("R8 clear rest", r, pack2(4'h9, 4'h0));
    chk("R9 disabled wire3", {28'h0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule